// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control half of a 10-bit successive-approximation converter inside a microcontroller. A firmware write to the GO bit opens the sample switch and starts a conversion. The block then produces a conversion-clock tick, either by dividing the system clock or from an asynchronous RC oscillator input. It drives a trial code to the external DAC and reads the external comparator once per tick to settle one result bit at a time, from the most significant bit down.

After twelve conversion-clock periods the block updates the result register in one step, clears the GO/DONE bit and sets a sticky interrupt flag. It then closes the sample switch again, aligned to the last quarter of the instruction cycle. The quarter-cycle phase is tracked internally from reset, and one instruction cycle is four system clocks. Writing zero to GO while a conversion runs cancels it. A cancelled conversion leaves the result and the flag untouched.

Top module: `sar_conv_seq`

## Requirements
- R1: The clock select `clk_sel` picks the conversion clock: 0 gives the system clock divided by 2, 1 divides by 8, 2 divides by 32 and 3 selects the RC input. In the three divider modes, GO/DONE stays high for exactly 12 x divide system clocks after the clock edge that accepts the start write.
- R2: Bit 9 is resolved first and bit 0 last. In each bit period the trial bit is set on `dac_code`, and it is kept only if `cmp_hi` is 1 (input at or above the DAC level) at the end of the period. With an ideal comparator, the result equals the input code. `dac_code` is zero whenever no conversion is running.
- R3: In RC mode, rising edges of `rc_clk` are ignored for the first instruction cycle (4 system clocks) after the start. After that, each synchronized rising edge is one conversion-clock period. Without RC edges, the conversion does not advance.
- R4: `sample_en` goes low on the same edge that accepts the start, and it stays low for the whole conversion.
- R5: On the final period, `result`, the clearing of `go_busy` and the setting of `conv_flag` all take effect on one clock edge. The new result can be read in the cycle that follows.
- R6: After a conversion ends or is cancelled, `sample_en` returns high on the clock edge that closes the next fourth quarter (phase 3 of the 0..3 count that starts at 0 when reset is released). This happens 1 to 4 clocks after `go_busy` falls.
- R7: A start write (`go_wr` with `go_wdata`=1) is honoured only when the block is idle with sampling on. One written during a conversion is ignored, and the conversion length is unchanged.
- R8: Writing `go_wdata`=0 during a conversion cancels it on that edge. `result` keeps its value and `conv_flag` is not set.
- R9: `result` holds its previous value for the whole of a conversion.
- R10: `conv_flag` stays set until a `flag_clr` pulse. If both happen on the same edge, setting wins over clearing.
- R11: After reset, `go_busy`=0, `sample_en`=1, `result`=0, `conv_flag`=0 and `dac_code`=0.
- R12: The clock select is captured when the start is accepted. Changing `clk_sel` during a conversion does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst | input | 1 | Synchronous active-high reset |
| go_wr | input | 1 | Write strobe for the GO/DONE bit |
| go_wdata | input | 1 | Value written to GO/DONE |
| clk_sel | input | 2 | Conversion clock source select |
| rc_clk | input | 1 | Asynchronous RC oscillator clock |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| flag_clr | input | 1 | Clears the completion flag |
| dac_code | output | 10 | Trial code to the DAC |
| sample_en | output | 1 | Sample switch closed when high |
| go_busy | output | 1 | GO/DONE status |
| result | output | 10 | Conversion result register |
| conv_flag | output | 1 | Sticky conversion-complete flag |

## Verification
The bench uses the default parameters: 10 bits, 12 periods, dividers 2/8/32, four quarters per cycle and a two-stage RC synchronizer. These defaults make every divider period short enough to measure conversion length to the exact clock. The bench's comparator model compares a chosen input code with `dac_code`, so every result bit can be predicted, including the all-zero and all-one codes and the codes on either side of mid-scale. The quarter phase restarts at reset, so a cycle counter in the bench predicts where the sample switch closes again.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        CS_DIV_A = 2'b00,
        CS_DIV_B = 2'b01,
        CS_DIV_C = 2'b10,
        CS_RC    = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_RECON
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic abort;
    } go_req_t;

    function automatic logic [31:0] div_ratio(
        input clk_src_e    src,
        input int unsigned div_a,
        input int unsigned div_b,
        input int unsigned div_c
    );
        case (src)
            CS_DIV_A: return 32'(div_a);
            CS_DIV_B: return 32'(div_b);
            default:  return 32'(div_c);
        endcase
    endfunction

endpackage

// File: rtl/sar_seq_phase.sv
module sar_seq_phase #(
    parameter int QUARTERS = 4
) (
    input  logic clk,
    input  logic rst,
    output logic q_last
);
    localparam int PH_W = (QUARTERS > 1) ? $clog2(QUARTERS) : 1;
    localparam logic [PH_W-1:0] PH_END = PH_W'(QUARTERS - 1);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst)
            ph <= '0;
        else if (ph == PH_END)
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    assign q_last = (ph == PH_END);
endmodule

// File: rtl/sar_seq_tick.sv
module sar_seq_tick
    import sar_seq_pkg::*;
#(
    parameter int DIV_A       = 2,
    parameter int DIV_B       = 8,
    parameter int DIV_C       = 32,
    parameter int QUARTERS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_src_e src,
    input  logic     rc_clk,
    output logic     tick
);
    localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                             : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
    localparam int CNT_W   = $clog2(DIV_MAX);
    localparam int DLY_W   = $clog2(QUARTERS + 1);
    localparam logic [DLY_W-1:0] DLY_END = DLY_W'(QUARTERS);

    logic [31:0]            ratio;
    logic [CNT_W-1:0]       div_lim;
    logic [CNT_W-1:0]       div_cnt;
    logic                   div_tick;
    logic [SYNC_STAGES-1:0] rc_sync;
    logic                   rc_prev;
    logic                   rc_rise;
    logic [DLY_W-1:0]       dly;
    logic                   rc_tick;

    assign ratio   = div_ratio(src, DIV_A, DIV_B, DIV_C) - 32'd1;
    assign div_lim = ratio[CNT_W-1:0];

    // divided system clock
    always_ff @(posedge clk) begin
        if (rst || !run)
            div_cnt <= '0;
        else if (div_cnt == div_lim)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    assign div_tick = run && (src != CS_RC) && (div_cnt == div_lim);

    // RC input: synchronizer chain
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) rc_sync[0] <= 1'b0;
                else     rc_sync[0] <= rc_clk;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) rc_sync[g] <= 1'b0;
                else     rc_sync[g] <= rc_sync[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rc_prev <= 1'b0;
        else     rc_prev <= rc_sync[SYNC_STAGES-1];
    end

    assign rc_rise = rc_sync[SYNC_STAGES-1] & ~rc_prev;

    // one instruction cycle of hold-off before RC edges count
    always_ff @(posedge clk) begin
        if (rst || !run)
            dly <= '0;
        else if (dly != DLY_END)
            dly <= dly + 1'b1;
    end

    assign rc_tick = run && (src == CS_RC) && rc_rise && (dly == DLY_END);
    assign tick    = div_tick | rc_tick;
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int CONV_PERIODS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go_wr,
    input  logic                go_wdata,
    input  logic [1:0]          clk_sel,
    input  logic                cmp_hi,
    input  logic                tick,
    input  logic                flag_clr,
    input  logic                q_last,
    output logic                busy,
    output clk_src_e            src_q,
    output logic [RES_BITS-1:0] dac_code,
    output logic                sample_en,
    output logic [RES_BITS-1:0] result,
    output logic                conv_flag
);
    localparam int TC_W = $clog2(CONV_PERIODS);
    localparam logic [TC_W-1:0] T_LAST = TC_W'(CONV_PERIODS - 1);
    localparam logic [TC_W-1:0] T_RES  = TC_W'(RES_BITS);
    localparam logic [RES_BITS-1:0] MSB_TRIAL = RES_BITS'(1) << (RES_BITS - 1);

    seq_state_e          state;
    logic [TC_W-1:0]     tcnt;
    logic [RES_BITS-1:0] sar;
    logic [RES_BITS-1:0] sar_nxt;
    go_req_t             req;
    logic                decide;
    logic                finish;
    logic                done_evt;

    assign req.start = go_wr && go_wdata && (state == ST_IDLE);
    assign req.abort = go_wr && !go_wdata && (state == ST_CONV);

    assign decide   = tick && (tcnt >= TC_W'(1)) && (tcnt <= T_RES);
    assign finish   = tick && (tcnt == T_LAST);
    assign done_evt = (state == ST_CONV) && finish && !req.abort;

    // settle current trial bit, raise the next one
    always_comb begin
        sar_nxt = sar;
        for (int i = 0; i < RES_BITS; i++) begin
            if ((int'(tcnt) + i == RES_BITS) && !cmp_hi)
                sar_nxt[i] = 1'b0;
            if (int'(tcnt) + i + 1 == RES_BITS)
                sar_nxt[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            sar       <= '0;
            result    <= '0;
            sample_en <= 1'b1;
            src_q     <= CS_DIV_A;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req.start) begin
                        state     <= ST_CONV;
                        src_q     <= clk_src_e'(clk_sel);
                        sar       <= MSB_TRIAL;
                        tcnt      <= '0;
                        sample_en <= 1'b0;
                    end
                end
                ST_CONV: begin
                    if (req.abort) begin
                        state <= ST_RECON;
                        sar   <= '0;
                        tcnt  <= '0;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                        if (decide)
                            sar <= sar_nxt;
                        if (finish) begin
                            result <= sar;
                            state  <= ST_RECON;
                            sar    <= '0;
                            tcnt   <= '0;
                        end
                    end
                end
                ST_RECON: begin
                    if (q_last) begin
                        sample_en <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            conv_flag <= 1'b0;
        else if (done_evt)
            conv_flag <= 1'b1;
        else if (flag_clr)
            conv_flag <= 1'b0;
    end

    assign busy     = (state == ST_CONV);
    assign dac_code = sar;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int CONV_PERIODS = RES_BITS + 2,
    parameter int DIV_A        = 2,
    parameter int DIV_B        = 8,
    parameter int DIV_C        = 32,
    parameter int QUARTERS     = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go_wr,
    input  logic                go_wdata,
    input  logic [1:0]          clk_sel,
    input  logic                rc_clk,
    input  logic                cmp_hi,
    input  logic                flag_clr,
    output logic [RES_BITS-1:0] dac_code,
    output logic                sample_en,
    output logic                go_busy,
    output logic [RES_BITS-1:0] result,
    output logic                conv_flag
);
    logic     q4;
    logic     tick;
    clk_src_e src_q;

    sar_seq_phase #(.QUARTERS(QUARTERS)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .q_last (q4)
    );

    sar_seq_tick #(
        .DIV_A       (DIV_A),
        .DIV_B       (DIV_B),
        .DIV_C       (DIV_C),
        .QUARTERS    (QUARTERS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (go_busy),
        .src    (src_q),
        .rc_clk (rc_clk),
        .tick   (tick)
    );

    sar_seq_core #(
        .RES_BITS     (RES_BITS),
        .CONV_PERIODS (CONV_PERIODS)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .go_wr     (go_wr),
        .go_wdata  (go_wdata),
        .clk_sel   (clk_sel),
        .cmp_hi    (cmp_hi),
        .tick      (tick),
        .flag_clr  (flag_clr),
        .q_last    (q4),
        .busy      (go_busy),
        .src_q     (src_q),
        .dac_code  (dac_code),
        .sample_en (sample_en),
        .result    (result),
        .conv_flag (conv_flag)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                go_busy,
    input logic                sample_en,
    input logic                conv_flag,
    input logic                q4,
    input logic [RES_BITS-1:0] result,
    input logic [RES_BITS-1:0] dac_code
);
    AST_SAMPLE_OPEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        go_busy |-> !sample_en); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (go_busy && $past(go_busy)) |-> $stable(result)); // R9

    AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_flag) |-> $fell(go_busy)); // R5

    AST_RECON_ON_Q4: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_en) |-> $past(q4)); // R6

    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !go_busy |-> (dac_code == '0)); // R2

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(go_busy) |-> $past(sample_en)); // R7
endmodule

bind sar_conv_seq sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go_busy   (go_busy),
    .sample_en (sample_en),
    .conv_flag (conv_flag),
    .q4        (q4),
    .result    (result),
    .dac_code  (dac_code)
);

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go_wr = 1'b0;
    logic       go_wdata = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       rc_clk = 1'b0;
    logic       cmp_hi;
    logic       flag_clr = 1'b0;
    logic [9:0] dac_code;
    logic       sample_en;
    logic       go_busy;
    logic [9:0] result;
    logic       conv_flag;

    int  vin = 0;
    bit  rc_en = 1'b0;
    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    initial begin
        forever begin
            #50;
            if (rc_en) rc_clk = ~rc_clk;
            else       rc_clk = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    assign cmp_hi = (vin >= int'(dac_code));

    sar_conv_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .go_wr     (go_wr),
        .go_wdata  (go_wdata),
        .clk_sel   (clk_sel),
        .rc_clk    (rc_clk),
        .cmp_hi    (cmp_hi),
        .flag_clr  (flag_clr),
        .dac_code  (dac_code),
        .sample_en (sample_en),
        .go_busy   (go_busy),
        .result    (result),
        .conv_flag (conv_flag)
    );

    function automatic int div_of(input logic [1:0] s);
        case (s)
            2'd0: return 2;
            2'd1: return 8;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_conv(input logic [1:0] s, input int v);
        @(negedge clk);
        vin = v;
        clk_sel = s;
        go_wr = 1'b1;
        go_wdata = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go_wr = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (go_busy && n < 20000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_recon(input string tag);
        int k = 0;
        int prev = cyc;
        while (!sample_en && k < 8) begin
            prev = cyc;
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        chk(sample_en == 1'b1, tag, "sample switch closed again", int'(sample_en), 1);
        chk(prev % 4 == 3, tag, "reconnect quarter", prev % 4, 3);
        chk(k >= 1 && k <= 4, tag, "reconnect delay", k, 1);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic full_div(input logic [1:0] s, input int v);
        int n;
        int old_res = int'(result);
        start_conv(s, v);
        chk(go_busy == 1'b1, "R1", "busy after start", int'(go_busy), 1);
        chk(sample_en == 1'b0, "R4", "sampling stops at start", int'(sample_en), 0);
        chk(int'(result) == old_res, "R9", "old result during conversion", int'(result), old_res);
        wait_done(n);
        chk(n == 12 * div_of(s), "R1", "conversion length", n, 12 * div_of(s));
        chk(int'(result) == v, "R2", "result code", int'(result), v);
        chk(conv_flag == 1'b1, "R5", "flag at completion", int'(conv_flag), 1);
        check_recon("R6");
        clear_flag();
        chk(conv_flag == 1'b0, "R10", "flag cleared", int'(conv_flag), 0);
    endtask

    initial begin
        repeat (600000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int held;
        void'($urandom(32'h5A17_C0DE));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(go_busy == 1'b0, "R11", "reset busy", int'(go_busy), 0);
        chk(sample_en == 1'b1, "R11", "reset sample_en", int'(sample_en), 1);
        chk(result == 10'd0, "R11", "reset result", int'(result), 0);
        chk(conv_flag == 1'b0, "R11", "reset flag", int'(conv_flag), 0);
        chk(dac_code == 10'd0, "R11", "reset dac", int'(dac_code), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // directed codes, R1 R2 R5
        full_div(2'd0, 0);
        full_div(2'd0, 1023);
        full_div(2'd1, 512);
        full_div(2'd2, 511);
        full_div(2'd0, 341);

        // R10: set wins over a simultaneous clear
        start_conv(2'd0, 77);
        flag_clr = 1'b1;
        wait_done(n);
        chk(conv_flag == 1'b1, "R10", "set beats clear", int'(conv_flag), 1);
        flag_clr = 1'b0;
        check_recon("R6");
        clear_flag();

        // R7: second GO during conversion ignored
        start_conv(2'd1, 300);
        repeat (19) @(negedge clk);
        go_wr = 1'b1;
        go_wdata = 1'b1;
        @(negedge clk);
        go_wr = 1'b0;
        chk(int'(result) == 77, "R9", "result held mid conversion", int'(result), 77);
        wait_done(n);
        chk(n + 20 == 96, "R7", "length with extra GO", n + 20, 96);
        chk(int'(result) == 300, "R7", "result with extra GO", int'(result), 300);
        check_recon("R6");
        clear_flag();

        // R12: select change mid conversion
        start_conv(2'd0, 900);
        clk_sel = 2'd2;
        wait_done(n);
        chk(n == 24, "R12", "length after select change", n, 24);
        chk(int'(result) == 900, "R12", "result after select change", int'(result), 900);
        check_recon("R6");
        clear_flag();

        // R8: abort
        start_conv(2'd1, 700);
        repeat (29) @(negedge clk);
        go_wr = 1'b1;
        go_wdata = 1'b0;
        @(negedge clk);
        go_wr = 1'b0;
        chk(go_busy == 1'b0, "R8", "abort clears busy", int'(go_busy), 0);
        chk(int'(result) == 900, "R8", "abort keeps result", int'(result), 900);
        chk(conv_flag == 1'b0, "R8", "abort sets no flag", int'(conv_flag), 0);
        check_recon("R8");

        // R3: RC mode
        rc_en = 1'b1;
        start_conv(2'd3, 123);
        wait_done(n);
        chk(n >= 110 && n <= 140, "R3", "RC conversion length", n, 120);
        chk(int'(result) == 123, "R3", "RC result", int'(result), 123);
        check_recon("R6");
        clear_flag();

        // R3: no RC edges, no progress
        rc_en = 1'b0;
        start_conv(2'd3, 5);
        repeat (200) @(negedge clk);
        chk(go_busy == 1'b1, "R3", "stalled without RC clock", int'(go_busy), 1);
        chk(dac_code == 10'd512, "R3", "trial code stalled", int'(dac_code), 512);
        go_wr = 1'b1;
        go_wdata = 1'b0;
        @(negedge clk);
        go_wr = 1'b0;
        held = int'(result);
        chk(held == 123, "R8", "abort in RC keeps result", held, 123);
        check_recon("R8");

        // random mix
        for (int it = 0; it < 30; it++) begin
            int v = int'($urandom % 1024);
            if (it % 6 == 5) begin
                rc_en = 1'b1;
                start_conv(2'd3, v);
                wait_done(n);
                chk(int'(result) == v, "R3", "random RC result", int'(result), v);
                check_recon("R6");
                clear_flag();
                rc_en = 1'b0;
            end else begin
                full_div(2'($urandom % 3), v);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule